// File: doc/BRIEF.md
# Auto-Reload Down-Counter Timer

This block is a 16-bit periodic timer for a small microcontroller peripheral. Software sets it up through a byte-wide register bus. Two write-only bytes hold a 16-bit reload value. One read/write byte carries the interrupt mask bit and another carries the run bit. While the timer runs, the counter steps down by one on every tick of the selected tick source. When the counter steps past zero it raises a sticky pending flag and refills itself from the reload value in that same step, so a reload value of N gives one event every N+1 ticks.

The tick is a single-cycle enable pulse that is synchronous to the block clock. A 2-bit mode input picks the pulse. In dual-clock mode and in slow-only mode the slow pulse drives the counter. In fast-only mode the fast pulse drives it. The fourth code selects neither pulse.

The counter clears to zero on reset. If the timer is started before a reload value is written, the first tick therefore produces an event at once and loads the reload value.

A two-state machine controls counting. `ST_HALT` holds the count. `ST_RUN` counts on ticks. The transition *start* (`ST_HALT` to `ST_RUN`) happens on the first clock edge at which the run bit is 1. The transition *stop* (`ST_RUN` to `ST_HALT`) happens on the first clock edge at which the run bit is 0.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter is 0x0000, every register byte is 0x00, the pending flag is clear and `irq` is 0.
- R2: A read of address 0x02 (mask byte) or 0x09 (run byte) returns the whole byte last written there. A read of the reload bytes 0x03 (low) and 0x04 (high), or of any other address, returns 0x00.
- R3: Bit 2 of the byte at 0x09 is the run bit. While it is 0 the count is frozen. When it returns to 1, counting resumes from the frozen value with no reload.
- R4: In `ST_RUN` each selected tick lowers the counter by one. A tick seen at a count of 0x0000 raises an underflow and loads {byte 0x04, byte 0x03} in place of 0xFFFF. With a reload value of N, underflows are N+1 ticks apart.
- R5: If the timer is started straight after reset, its first tick underflows.
- R6: Mode input 0 (dual) and mode input 1 (slow only) count on `slow_tick`. Mode input 2 (fast only) counts on `fast_tick`. Mode input 3 counts on neither. The unselected pulse has no effect.
- R7: An underflow sets the pending flag. The flag stays set until a cycle with `pend_clr` high clears it. If an underflow and a clear fall in the same cycle, the set wins.
- R8: `irq` is the pending flag ANDed with bit 2 of the byte at 0x02. A pending flag that was set while masked shows on `irq` one cycle after bit 2 is written to 1.
- R9: A write to the reload bytes leaves the running count alone. The new value is used from the next underflow onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe; the write takes place at the clock edge |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| slow_tick | input | 1 | Single-cycle slow tick pulse |
| fast_tick | input | 1 | Single-cycle fast tick pulse |
| clk_mode | input | 2 | Clock mode: 0 dual, 1 slow only, 2 fast only, 3 none |
| pend_clr | input | 1 | Clears the pending flag |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write takes effect at the clock edge on which `bus_we` is sampled. A tick at edge k moves the counter at edge k. An underflow at edge k makes `irq` high from edge k onward. A new mask bit changes `irq` one edge after the write. `bus_rdata` follows the address with no register in between.

The bench drives its inputs on falling edges. It reads `irq` on the next falling edge, which is one rising edge after the stimulus. For reads, it samples `bus_rdata` a short delay after setting the address. Periods are measured by applying ticks one at a time until `irq` rises. The measured count is then compared with N+1, where N is taken from the value the bench wrote.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int CW = 16;

    localparam logic [AW-1:0] A_MASK = 8'h02;
    localparam logic [AW-1:0] A_RLO  = 8'h03;
    localparam logic [AW-1:0] A_RHI  = 8'h04;
    localparam logic [AW-1:0] A_RUN  = 8'h09;
    localparam int            CTL_BIT = 2;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic [1:0] {
        MODE_DUAL = 2'd0,
        MODE_SLOW = 2'd1,
        MODE_FAST = 2'd2,
        MODE_NONE = 2'd3
    } clk_mode_t;
endpackage

// File: rtl/rt_regs.sv
module rt_regs
    import rt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic [CW-1:0] reload,
    output logic          mask_bit,
    output logic          run_bit
);
    localparam int HALF = CW / 2;

    logic [DW-1:0]   mask_q, run_q;
    logic [HALF-1:0] rlo_q, rhi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            run_q  <= '0;
            rlo_q  <= '0;
            rhi_q  <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_MASK:  mask_q <= bus_wdata;
                A_RUN:   run_q  <= bus_wdata;
                A_RLO:   rlo_q  <= bus_wdata[HALF-1:0];
                A_RHI:   rhi_q  <= bus_wdata[HALF-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_MASK:  bus_rdata = mask_q;
            A_RUN:   bus_rdata = run_q;
            default: bus_rdata = '0;
        endcase
    end

    assign reload   = {rhi_q, rlo_q};
    assign mask_bit = mask_q[CTL_BIT];
    assign run_bit  = run_q[CTL_BIT];

    // R2: reload bytes are never visible on the read path
    p_wo_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_RLO || bus_addr == A_RHI) |-> bus_rdata == '0);
endmodule

// File: rtl/rt_tick_sel.sv
module rt_tick_sel
    import rt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_mode,
    input  logic       slow_tick,
    input  logic       fast_tick,
    output logic       tick
);
    always_comb begin
        unique case (clk_mode_t'(clk_mode))
            MODE_DUAL: tick = slow_tick;
            MODE_SLOW: tick = slow_tick;
            MODE_FAST: tick = fast_tick;
            MODE_NONE: tick = 1'b0;
        endcase
    end

    // R6: the unused code never produces a tick
    p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == MODE_NONE) |-> !tick);
endmodule

// File: rtl/rt_counter.sv
module rt_counter
    import rt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_bit,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    output logic          wrap
);
    run_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_bit)  state_d = ST_RUN;
            ST_RUN:  if (!run_bit) state_d = ST_HALT;
        endcase
    end

    // outputs and next count
    always_comb begin
        wrap  = 1'b0;
        cnt_d = cnt_q;
        unique case (state_q)
            ST_HALT: cnt_d = cnt_q;
            ST_RUN: begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        wrap  = 1'b1;
                        cnt_d = reload;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && cnt_q == '0) |=> cnt_q == $past(reload));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_RUN && tick) |=> $stable(cnt_q));
    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_bit |=> state_q == ST_HALT);
endmodule

// File: rtl/rt_pending.sv
module rt_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic pend_clr,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend <= 1'b0;
        else if (wrap)     pend <= 1'b1;
        else if (pend_clr) pend <= 1'b0;
    end

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pend);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !wrap) |=> !pend);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    input  logic          slow_tick,
    input  logic          fast_tick,
    input  logic [1:0]    clk_mode,
    input  logic          pend_clr,
    output logic          irq
);
    logic [CW-1:0] reload;
    logic          mask_bit, run_bit, tick, wrap, pend;

    rt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .reload(reload),
        .mask_bit(mask_bit), .run_bit(run_bit)
    );

    rt_tick_sel u_tick (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .tick(tick)
    );

    rt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .run_bit(run_bit), .tick(tick),
        .reload(reload), .wrap(wrap)
    );

    rt_pending u_pend (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .pend_clr(pend_clr), .pend(pend)
    );

    assign irq = pend & mask_bit;

    // R8: a masked request never reaches the output
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_bit |-> !irq);
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_we = 1'b0, slow_tick = 1'b0, fast_tick = 1'b0, pend_clr = 1'b0;
    logic [1:0] clk_mode = 2'd0;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    reload_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .slow_tick(slow_tick),
        .fast_tick(fast_tick), .clk_mode(clk_mode), .pend_clr(pend_clr), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, int'(bus_rdata), int'(exp));
    endtask

    task automatic pulse(input bit fast);
        @(negedge clk);
        if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
        @(negedge clk);
        fast_tick = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); pend_clr = 1'b1;
        @(negedge clk); pend_clr = 1'b0;
    endtask

    // ticks needed until irq rises
    task automatic measure(input bit fast, output int n);
        n = 0;
        do begin
            pulse(fast);
            n++;
        end while (!irq && n < 70000);
    endtask

    task automatic set_reload(input int v);
        wr(8'h03, v[7:0]);
        wr(8'h04, v[15:8]);
    endtask

    // bring the counter onto the current reload value, pending clear
    task automatic sync(input int v);
        int n;
        set_reload(v);
        measure(1'b0, n);
        clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int vals[8] = '{1, 2, 3, 5, 8, 255, 256, 4660};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check("R1 irq", int'(irq), 0);
        rd_check("R1 mask byte", 8'h02, 8'h00);
        rd_check("R1 run byte", 8'h09, 8'h00);

        wr(8'h02, 8'h04);
        wr(8'h09, 8'h04);
        repeat (2) @(negedge clk);
        check("R1 no event without tick", int'(irq), 0);
        pulse(1'b0);
        check("R5 first tick underflows", int'(irq), 1);
        repeat (5) @(negedge clk);
        check("R7 pending sticky", int'(irq), 1);
        clear();
        check("R7 cleared", int'(irq), 0);
        measure(1'b0, n);
        check("R4 period N=0", n, 1);
        clear();

        // R4 period sweep
        foreach (vals[i]) begin
            sync(vals[i]);
            measure(1'b0, n);
            check("R4 period N+1", n, vals[i] + 1);
            clear();
        end

        // R6 tick source selection, reload 2
        sync(2);
        clk_mode = 2'd2;
        repeat (5) pulse(1'b0);
        check("R6 fast mode ignores slow", int'(irq), 0);
        measure(1'b1, n);
        check("R6 fast mode period", n, 3);
        clear();
        clk_mode = 2'd1;
        repeat (5) pulse(1'b1);
        check("R6 slow mode ignores fast", int'(irq), 0);
        measure(1'b0, n);
        check("R6 slow mode period", n, 3);
        clear();
        clk_mode = 2'd3;
        repeat (4) pulse(1'b0);
        repeat (4) pulse(1'b1);
        check("R6 mode 3 no tick", int'(irq), 0);
        clk_mode = 2'd0;
        repeat (4) pulse(1'b1);
        check("R6 dual ignores fast", int'(irq), 0);
        measure(1'b0, n);
        check("R6 dual period", n, 3);
        clear();

        // R3 freeze and resume, reload 4
        sync(4);
        repeat (2) pulse(1'b0);
        wr(8'h09, 8'h00);
        repeat (6) pulse(1'b0);
        check("R3 frozen no event", int'(irq), 0);
        wr(8'h09, 8'h04);
        measure(1'b0, n);
        check("R3 resume without reload", n, 3);
        clear();

        // R9 reload write mid-count
        sync(4);
        repeat (2) pulse(1'b0);
        set_reload(9);
        measure(1'b0, n);
        check("R9 running count kept", n, 3);
        clear();
        measure(1'b0, n);
        check("R9 new reload after underflow", n, 10);
        clear();

        // R8 masking, count now 9
        wr(8'h02, 8'h00);
        repeat (10) pulse(1'b0);
        check("R8 masked irq low", int'(irq), 0);
        wr(8'h02, 8'h04);
        check("R8 pending shown on unmask", int'(irq), 1);
        clear();

        // R2 read path
        wr(8'h09, 8'hA4);
        rd_check("R2 run byte", 8'h09, 8'hA4);
        wr(8'h02, 8'h5A);
        rd_check("R2 mask byte", 8'h02, 8'h5A);
        rd_check("R2 reload low reads 0", 8'h03, 8'h00);
        rd_check("R2 reload high reads 0", 8'h04, 8'h00);
        rd_check("R2 other address", 8'h10, 8'h00);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule